// File: doc/BRIEF.md
# Two-Lane Feedforward Sample Shuffler

This block reorders a stream of complex samples that arrives two per clock, on an upper and a lower lane, between two stages of a two-lane parallel pipelined FFT. The next butterfly stage needs each pair of samples whose indices differ by a distance `LANE_SPAN` to arrive on the same clock. The shuffler gets there with no arithmetic. It has one circular buffer of depth `LANE_SPAN` on the lower input, one on the upper output, and a two-way lane exchange between them. The exchange is steered by one bit of a counter that advances only on cycles where the input is valid.

Within every block of `2*LANE_SPAN` valid inputs, the first half is a straight phase and the second half is a cross phase. In the cross phase the current upper sample goes straight to the lower output, and the delayed lower sample moves on into the output-side buffer. In the straight phase the upper sample is parked in the output-side buffer and the lower output is taken from the input-side buffer. The controller is a three-state machine:

- FILL, entered at reset, covers the first `LANE_SPAN` valid inputs and produces no output. The transition FILL to CROSS is taken on the valid input that completes the fill.
- CROSS to STRAIGHT is taken on the last valid input of a half-block.
- STRAIGHT to CROSS is taken on the last valid input of a half-block.

Top module: `fft_lane_shuffler`

## Requirements
- R1: While and right after reset, `out_valid` is 0 and all four output data fields are 0.
- R2: Counting valid inputs from 0 after reset, inputs 0 to `LANE_SPAN-1` produce no output. Every valid input with index `LANE_SPAN` or higher raises `out_valid` on the following clock.
- R3: For a valid input with index t where t mod (2*`LANE_SPAN`) is `LANE_SPAN` or higher (cross phase), the next output pair is upper = upper input t-`LANE_SPAN` and lower = upper input t.
- R4: For a valid input with index t of 2*`LANE_SPAN` or higher where t mod (2*`LANE_SPAN`) is below `LANE_SPAN` (straight phase), the next output pair is upper = lower input t-2*`LANE_SPAN` and lower = lower input t-`LANE_SPAN`.
- R5: A cycle with `in_valid` low advances nothing. On the next clock `out_valid` is 0 and the output data fields keep their values. The stream then carries on as if the gap were absent.
- R6: The lane-exchange select is a counter bit. It changes exactly after every `LANE_SPAN` valid inputs and at no other time.
- R7: A reset in the middle of a stream discards all buffered samples and restarts the fill of R2.
- R8: The real and imaginary fields are carried bit-exact as signed `SAMPLE_W`-bit values, including the most negative and most positive codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Both input lanes carry a sample this cycle |
| up_re | input | SAMPLE_W | Upper input lane, real part (signed) |
| up_im | input | SAMPLE_W | Upper input lane, imaginary part (signed) |
| lo_re | input | SAMPLE_W | Lower input lane, real part (signed) |
| lo_im | input | SAMPLE_W | Lower input lane, imaginary part (signed) |
| out_valid | output | 1 | Output pair is new this cycle |
| out_up_re | output | SAMPLE_W | Upper output lane, real part |
| out_up_im | output | SAMPLE_W | Upper output lane, imaginary part |
| out_lo_re | output | SAMPLE_W | Lower output lane, real part |
| out_lo_im | output | SAMPLE_W | Lower output lane, imaginary part |

## Verification
The bench runs several blocks back to back, so that the cross and straight phases alternate more than once. An off-by-one in the select bit would pair samples from the wrong half-block, and each pair is compared against the index arithmetic of R3 and R4. Gaps in `in_valid` are inserted at irregular points, including right at phase boundaries. A counter that advanced on idle cycles would shift every later pair, and output registers that loaded on idle cycles would break the hold. A reset in mid-stream checks that stale buffer contents never reach the outputs, and a run of full-scale codes catches swapped or truncated real and imaginary fields.

// File: rtl/fft_shuffle_pkg.sv
`timescale 1ns/1ps
package fft_shuffle_pkg;

    typedef enum logic [1:0] {
        SH_FILL     = 2'd0,
        SH_CROSS    = 2'd1,
        SH_STRAIGHT = 2'd2
    } shuf_state_e;

    function automatic int unsigned span_bits(input int unsigned span);
        return (span < 2) ? 1 : $clog2(span);
    endfunction

endpackage

// File: rtl/fft_shuffle_ctrl.sv
`timescale 1ns/1ps
module fft_shuffle_ctrl
    import fft_shuffle_pkg::*;
#(
    parameter int unsigned LANE_SPAN = 8,
    localparam int unsigned AW = span_bits(LANE_SPAN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          sel,
    output logic [AW-1:0] addr,
    output logic          emit,
    output shuf_state_e   state
);

    logic [AW:0] cnt_q;
    shuf_state_e state_q;
    shuf_state_e state_d;
    logic half_end;

    assign half_end = (cnt_q[AW-1:0] == AW'(LANE_SPAN - 1));

    // counter: advances on valid input only
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (in_valid) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_FILL:     if (in_valid && half_end) state_d = SH_CROSS;
            SH_CROSS:    if (in_valid && half_end) state_d = SH_STRAIGHT;
            SH_STRAIGHT: if (in_valid && half_end) state_d = SH_CROSS;
            default:     state_d = SH_FILL;
        endcase
    end

    // outputs
    always_comb begin
        sel  = cnt_q[AW];
        addr = cnt_q[AW-1:0];
        unique case (state_q)
            SH_FILL:     emit = 1'b0;
            SH_CROSS:    emit = in_valid;
            SH_STRAIGHT: emit = in_valid;
            default:     emit = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/fft_shuffle_buf.sv
`timescale 1ns/1ps
module fft_shuffle_buf #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 32,
    parameter int unsigned AW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    // The slot at addr was written exactly DEPTH enabled cycles ago.
    assign rd_data = mem[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (en) begin
            mem[addr] <= wr_data;
        end
    end

endmodule

// File: rtl/fft_shuffle_xbar.sv
`timescale 1ns/1ps
module fft_shuffle_xbar #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] up_in,
    input  logic [WIDTH-1:0] in_head,
    output logic [WIDTH-1:0] park_data,
    output logic [WIDTH-1:0] lo_next
);

    always_comb begin
        if (sel) begin
            park_data = in_head;
            lo_next   = up_in;
        end else begin
            park_data = up_in;
            lo_next   = in_head;
        end
    end

endmodule

// File: rtl/fft_lane_shuffler.sv
`timescale 1ns/1ps
module fft_lane_shuffler
    import fft_shuffle_pkg::*;
#(
    parameter int unsigned LANE_SPAN = 8,
    parameter int unsigned SAMPLE_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] up_re,
    input  logic signed [SAMPLE_W-1:0] up_im,
    input  logic signed [SAMPLE_W-1:0] lo_re,
    input  logic signed [SAMPLE_W-1:0] lo_im,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_up_re,
    output logic signed [SAMPLE_W-1:0] out_up_im,
    output logic signed [SAMPLE_W-1:0] out_lo_re,
    output logic signed [SAMPLE_W-1:0] out_lo_im
);

    localparam int unsigned AW = span_bits(LANE_SPAN);
    localparam int unsigned CW = 2 * SAMPLE_W;

    logic          sel_w;
    logic [AW-1:0] addr_w;
    logic          emit_w;
    shuf_state_e   state_w;

    logic [CW-1:0] up_pack;
    logic [CW-1:0] lo_pack;
    logic [CW-1:0] in_head;
    logic [CW-1:0] out_head;
    logic [CW-1:0] park_w;
    logic [CW-1:0] lo_next;
    logic [CW-1:0] up_q;
    logic [CW-1:0] lo_q;
    logic          ov_q;

    assign up_pack = {up_re, up_im};
    assign lo_pack = {lo_re, lo_im};

    fft_shuffle_ctrl #(.LANE_SPAN(LANE_SPAN)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .sel      (sel_w),
        .addr     (addr_w),
        .emit     (emit_w),
        .state    (state_w)
    );

    // input-side buffer: delays the lower lane
    fft_shuffle_buf #(.DEPTH(LANE_SPAN), .WIDTH(CW), .AW(AW)) u_in_buf (
        .clk     (clk),
        .rst     (rst),
        .en      (in_valid),
        .addr    (addr_w),
        .wr_data (lo_pack),
        .rd_data (in_head)
    );

    fft_shuffle_xbar #(.WIDTH(CW)) u_xbar (
        .sel       (sel_w),
        .up_in     (up_pack),
        .in_head   (in_head),
        .park_data (park_w),
        .lo_next   (lo_next)
    );

    // output-side buffer: feeds the upper output
    fft_shuffle_buf #(.DEPTH(LANE_SPAN), .WIDTH(CW), .AW(AW)) u_out_buf (
        .clk     (clk),
        .rst     (rst),
        .en      (in_valid),
        .addr    (addr_w),
        .wr_data (park_w),
        .rd_data (out_head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q <= '0;
            lo_q <= '0;
            ov_q <= 1'b0;
        end else begin
            ov_q <= emit_w;
            if (emit_w) begin
                up_q <= out_head;
                lo_q <= lo_next;
            end
        end
    end

    assign out_valid = ov_q;
    assign out_up_re = up_q[CW-1:SAMPLE_W];
    assign out_up_im = up_q[SAMPLE_W-1:0];
    assign out_lo_re = lo_q[CW-1:SAMPLE_W];
    assign out_lo_im = lo_q[SAMPLE_W-1:0];

endmodule

// File: rtl/fft_lane_shuffler_chk.sv
`timescale 1ns/1ps
module fft_lane_shuffler_chk #(
    parameter int unsigned LANE_SPAN = 8,
    parameter int unsigned SAMPLE_W  = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                sel,
    input logic [SAMPLE_W-1:0] up_re,
    input logic [SAMPLE_W-1:0] up_im,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_up_re,
    input logic [SAMPLE_W-1:0] out_up_im,
    input logic [SAMPLE_W-1:0] out_lo_re,
    input logic [SAMPLE_W-1:0] out_lo_im
);

    localparam int unsigned SW = $clog2(LANE_SPAN + 1);
    localparam int unsigned PW = (LANE_SPAN < 2) ? 1 : $clog2(LANE_SPAN);

    logic [SW-1:0] seen;
    logic [PW-1:0] ph;
    logic          filled;

    assign filled = (seen == SW'(LANE_SPAN));

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
            ph   <= '0;
        end else if (in_valid) begin
            if (!filled) seen <= seen + 1'b1;
            ph <= (ph == PW'(LANE_SPAN - 1)) ? '0 : ph + 1'b1;
        end
    end

    p_gap_novalid_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_gap_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_up_re) && $stable(out_up_im)
                       && $stable(out_lo_re) && $stable(out_lo_im)));

    p_fill_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !filled) |=> !out_valid);

    p_emit_after_fill_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && filled) |=> out_valid);

    p_cross_direct_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && filled && sel) |=>
            (out_lo_re == $past(up_re) && out_lo_im == $past(up_im)));

    p_sel_toggle_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ph == PW'(LANE_SPAN - 1)) |=> (sel != $past(sel)));

    p_sel_steady_r6: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && ph == PW'(LANE_SPAN - 1)) |=> $stable(sel));

endmodule

bind fft_lane_shuffler fft_lane_shuffler_chk #(
    .LANE_SPAN (LANE_SPAN),
    .SAMPLE_W  (SAMPLE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sel       (sel_w),
    .up_re     (up_re),
    .up_im     (up_im),
    .out_valid (out_valid),
    .out_up_re (out_up_re),
    .out_up_im (out_up_im),
    .out_lo_re (out_lo_re),
    .out_lo_im (out_lo_im)
);

// File: tb/tb_fft_lane_shuffler.sv
`timescale 1ns/1ps
module tb_fft_lane_shuffler;

    localparam int L = 8;
    localparam int W = 16;
    localparam int HIST = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [W-1:0] up_re = '0, up_im = '0, lo_re = '0, lo_im = '0;
    logic out_valid;
    logic signed [W-1:0] out_up_re, out_up_im, out_lo_re, out_lo_im;

    always #2 clk = ~clk;

    fft_lane_shuffler #(.LANE_SPAN(L), .SAMPLE_W(W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .up_re(up_re), .up_im(up_im), .lo_re(lo_re), .lo_im(lo_im),
        .out_valid(out_valid),
        .out_up_re(out_up_re), .out_up_im(out_up_im),
        .out_lo_re(out_lo_re), .out_lo_im(out_lo_im)
    );

    typedef struct {
        logic v;
        logic signed [W-1:0] ur, ui, lr, li;
        string tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic signed [W-1:0] hur [HIST];
    logic signed [W-1:0] hui [HIST];
    logic signed [W-1:0] hdr [HIST];
    logic signed [W-1:0] hdi [HIST];
    int t = 0;
    logic signed [W-1:0] lur = '0, lui = '0, llr = '0, lli = '0;

    task automatic do_reset(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            item_t it;
            @(negedge clk);
            rst = 1'b1;
            in_valid = 1'b0;
            it.v = 1'b0; it.ur = '0; it.ui = '0; it.lr = '0; it.li = '0;
            it.tag = "R1";
            q.push_back(it);
        end
        t = 0;
        lur = '0; lui = '0; llr = '0; lli = '0;
    endtask

    task automatic drive(input bit v, input logic signed [W-1:0] ur, ui, lr, li,
                         input string tag);
        item_t it;
        @(negedge clk);
        rst = 1'b0;
        in_valid = v;
        up_re = ur; up_im = ui; lo_re = lr; lo_im = li;
        it.v = 1'b0;
        it.tag = "R5";
        if (v) begin
            hur[t] = ur; hui[t] = ui; hdr[t] = lr; hdi[t] = li;
            if (t < L) begin
                it.tag = "R2";
            end else if ((t % (2*L)) >= L) begin
                it.v = 1'b1;
                lur = hur[t-L]; lui = hui[t-L]; llr = hur[t]; lli = hui[t];
                it.tag = (tag == "") ? "R3" : tag;
            end else begin
                it.v = 1'b1;
                lur = hdr[t-2*L]; lui = hdi[t-2*L]; llr = hdr[t-L]; lli = hdi[t-L];
                it.tag = (tag == "") ? "R4" : tag;
            end
            t++;
        end
        it.ur = lur; it.ui = lui; it.lr = llr; it.li = lli;
        q.push_back(it);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t e;
                e = q.pop_front();
                checks++;
                if (out_valid !== e.v || out_up_re !== e.ur || out_up_im !== e.ui
                    || out_lo_re !== e.lr || out_lo_im !== e.li) begin
                    failures++;
                    $display("FAIL %s: got v=%0b up=(%0d,%0d) lo=(%0d,%0d) exp v=%0b up=(%0d,%0d) lo=(%0d,%0d)",
                             e.tag, out_valid, out_up_re, out_up_im, out_lo_re, out_lo_im,
                             e.v, e.ur, e.ui, e.lr, e.li);
                end
            end
        end
    end

    function automatic logic signed [W-1:0] val(input int run, input int k, input int lane);
        return W'(run * 1000 + k * 4 + lane - 300);
    endfunction

    initial begin
        // R1: reset state
        do_reset(3);

        // R2 R3 R4 R6: continuous stream over several blocks
        for (int k = 0; k < 6*L; k++)
            drive(1'b1, val(1,k,0), val(1,k,1), val(1,k,2), val(1,k,3), "");

        // R5: irregular gaps, including at phase boundaries
        for (int k = 0; k < 6*L; k++) begin
            if (k % 5 == 2 || k % 7 == 0) drive(1'b0, 16'sd77, -16'sd77, 16'sd55, -16'sd55, "");
            drive(1'b1, val(2,k,0), val(2,k,1), val(2,k,2), val(2,k,3), "");
        end
        drive(1'b0, '0, '0, '0, '0, "");
        drive(1'b0, '0, '0, '0, '0, "");

        // R7: reset mid-stream, then refill
        for (int k = 0; k < L + 3; k++)
            drive(1'b1, val(3,k,0), val(3,k,1), val(3,k,2), val(3,k,3), "");
        do_reset(1);
        for (int k = 0; k < 4*L; k++)
            drive(1'b1, val(4,k,0), val(4,k,1), val(4,k,2), val(4,k,3),
                  (k >= L && k < 2*L) ? "R7" : "");

        // R8: full-scale codes
        do_reset(1);
        for (int k = 0; k < 4*L; k++) begin
            logic signed [W-1:0] a, b;
            a = (k % 2 == 0) ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
            b = (k % 3 == 0) ? {1'b0, {(W-1){1'b1}}} : {1'b1, {(W-1){1'b0}}};
            drive(1'b1, a, b, b, a, (k >= L) ? "R8" : "");
        end
        drive(1'b0, '0, '0, '0, '0, "");
        repeat (4) @(negedge clk);

        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R5: scoreboard left %0d items, expected 0", q.size());
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule